// File: doc/BRIEF.md
# Dynamic Link Frame Packer

The packer takes variable-length events from a FIFO and lays their bits end to end into fixed frames for a serial link. Each event is a 24-bit event header that may be followed by a payload whose bit count is carried in the header. Bits go into a staging accumulator one after another, least significant bit first, with no gap between events. An event may therefore begin in one frame and finish in the next.

A frame leaves on each frame strobe, which marks the start of a link frame period. The frame is an 84-bit payload under a 4-bit code. That code marks the frame as data or idle.

When a full payload's worth of bits is staged, a data frame is sent. When fewer bits are staged and the FIFO is empty, the partial content is flushed as a zero-padded data frame. This is how a run of header-only events ends up sharing one frame. In every other case the frame is idle.

While the synchronisation input is high, each strobe yields an alignment frame instead: the current crossing number in an event-header slot, followed by a programmable pattern. All staged bits are thrown away, so the first event after synchronisation starts on bit 0 of a fresh frame.

Top module: `link_frame_packer`

## Requirements
- R1: `frame_o[87:84]` is the frame code, 0x5 for a data frame and 0x6 for an idle frame. `frame_o[83:0]` is the payload, and bit 0 is the first bit placed on the link.
- R2: `frame_vld_o` is high for exactly the one cycle after each cycle in which `frame_stb_i` is high, and is low at all other times. One frame is produced per strobe.
- R3: An event is made of its 24-bit header and then the low `size` bits of `ev_data_i`. The header fields are crossing number [11:0], status [15:12] and `size` [23:16], with `size` from 0 to 48. Payload bits at or above `size` are ignored and never reach a frame.
- R4: Events are packed back to back in FIFO order. There is no padding between them, and an event may continue across one or more frame boundaries.
- R5: When at least 84 bits are staged at a strobe, the frame is a data frame holding the oldest 84 staged bits. The remaining bits move down to the front.
- R6: When between 1 and 83 bits are staged at a strobe and `ev_empty_i` is high, the frame is a data frame holding those bits, with the unused high payload bits set to zero. For example, three header-only events give 72 bits followed by 12 zeros.
- R7: When nothing is staged at a strobe, or when fewer than 84 bits are staged and the FIFO is not empty, the frame is idle with an all-zero payload.
- R8: `ev_rd_o` pops one event only under all three of these conditions: the FIFO is not empty, synchronisation is low, and the staged bits plus the event length fit in 168 bits. The staged count used here is the count after any frame taken in the same cycle.
- R9: With `sync_i` high at a strobe, the frame has code 0x5. Its payload holds `bxid_i` in [11:0], zeros in [23:12] and `align_pat_i` in [83:24]. While `sync_i` is high, all staged bits are discarded and no event is read.
- R10: The first event read after `sync_i` falls begins at payload bit 0 of the next data frame.
- R11: While reset is active, and after it, `frame_o` is zero and `frame_vld_o` is low, with nothing staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | Start of a link frame period |
| sync_i | input | 1 | Synchronisation request; selects the alignment frame |
| bxid_i | input | 12 | Current crossing number |
| align_pat_i | input | 60 | Alignment pattern placed in synchronisation frames |
| ev_empty_i | input | 1 | Event FIFO empty |
| ev_hdr_i | input | 24 | Event header at the FIFO head |
| ev_data_i | input | 48 | Event payload at the FIFO head |
| ev_rd_o | output | 1 | Pop the FIFO head |
| frame_o | output | 88 | Frame code and payload |
| frame_vld_o | output | 1 | Frame valid, one cycle per strobe |

## Verification
The assertions assume two things about the inputs. First, the FIFO head holds a header whose size field never exceeds the payload width. Second, `ev_empty_i` is a true FIFO flag, so `ev_rd_o` never pops an absent entry.

The stimulus keeps to these rules by construction. It draws sizes only from 0 to 48, but fills the payload bits above the size with random values so that the masking is exercised. It presents its own queue head and pops only on `ev_rd_o`.

Strobes come every third cycle. Synchronisation bursts of random length, together with a random FIFO fill, cover data, flush, idle and alignment frames and events that straddle frames.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
  localparam logic [3:0] CODE_DATA = 4'h5;
  localparam logic [3:0] CODE_IDLE = 4'h6;

  typedef enum logic [1:0] {
    FK_IDLE  = 2'd0,
    FK_FULL  = 2'd1,
    FK_FLUSH = 2'd2,
    FK_SYNC  = 2'd3
  } frame_kind_e;
endpackage

// File: rtl/lfp_item_fmt.sv
module lfp_item_fmt #(
  parameter int HDR_W  = 24,
  parameter int DATA_W = 48,
  parameter int SIZE_W = 8,
  parameter int ITEM_W = 72,
  parameter int LEN_W  = 7
) (
  input  logic [HDR_W-1:0]  hdr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ITEM_W-1:0] item_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [SIZE_W-1:0] size;

  assign size = hdr_i[HDR_W-1 -: SIZE_W];
  assign item_o[HDR_W-1:0] = hdr_i;

  // payload bits above the size field are masked off
  for (genvar k = 0; k < DATA_W; k++) begin : g_mask
    assign item_o[HDR_W+k] = data_i[k] & (SIZE_W'(k) < size);
  end

  assign len_o = LEN_W'(HDR_W) + LEN_W'(size);
endmodule

// File: rtl/lfp_accum.sv
module lfp_accum
  import lfp_pkg::*;
#(
  parameter int FRAME_W = 84,
  parameter int ITEM_W  = 72,
  parameter int LEN_W   = 7,
  parameter int ACC_W   = 168,
  parameter int FILL_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_stb_i,
  input  logic               sync_i,
  input  logic               ev_empty_i,
  input  logic [ITEM_W-1:0]  item_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               rd_o,
  output frame_kind_e        kind_o,
  output logic [FRAME_W-1:0] bits_o,
  output logic [FILL_W-1:0]  fill_o
);
  logic [ACC_W-1:0]  acc_q, acc_s, acc_d;
  logic [FILL_W-1:0] fill_q, fill_s, fill_d;
  logic              emit_full, emit_flush, take, room;
  logic [FILL_W:0]   need;

  always_comb begin
    emit_full  = fill_q >= FILL_W'(FRAME_W);
    emit_flush = !emit_full && (fill_q != '0) && ev_empty_i;
    take       = frame_stb_i && !sync_i && (emit_full || emit_flush);

    // frame leaves first, the new event is appended behind what remains
    if (take && emit_full) begin
      acc_s  = acc_q >> FRAME_W;
      fill_s = fill_q - FILL_W'(FRAME_W);
    end else if (take) begin
      acc_s  = '0;
      fill_s = '0;
    end else begin
      acc_s  = acc_q;
      fill_s = fill_q;
    end

    need = (FILL_W+1)'(fill_s) + (FILL_W+1)'(len_i);
    room = need <= (FILL_W+1)'(ACC_W);
    rd_o = !sync_i && !ev_empty_i && room;

    if (rd_o) begin
      acc_d  = acc_s | (ACC_W'(item_i) << fill_s);
      fill_d = fill_s + FILL_W'(len_i);
    end else begin
      acc_d  = acc_s;
      fill_d = fill_s;
    end

    if (sync_i)          kind_o = FK_SYNC;
    else if (!take)      kind_o = FK_IDLE;
    else if (emit_full)  kind_o = FK_FULL;
    else                 kind_o = FK_FLUSH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else if (sync_i) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
    end
  end

  assign bits_o = acc_q[FRAME_W-1:0];
  assign fill_o = fill_q;
endmodule

// File: rtl/lfp_frame_out.sv
module lfp_frame_out
  import lfp_pkg::*;
#(
  parameter int FRAME_W = 84,
  parameter int HDR_W   = 24,
  parameter int BX_W    = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_stb_i,
  input  frame_kind_e              kind_i,
  input  logic [FRAME_W-1:0]       bits_i,
  input  logic [BX_W-1:0]          bxid_i,
  input  logic [FRAME_W-HDR_W-1:0] pat_i,
  output logic [FRAME_W+3:0]       frame_o,
  output logic                     vld_o
);
  logic [FRAME_W+3:0] frame_d;

  always_comb begin
    unique case (kind_i)
      FK_SYNC:           frame_d = {CODE_DATA, pat_i, (HDR_W-BX_W)'(0), bxid_i};
      FK_FULL, FK_FLUSH: frame_d = {CODE_DATA, bits_i};
      default:           frame_d = {CODE_IDLE, FRAME_W'(0)};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= frame_stb_i;
      if (frame_stb_i) frame_o <= frame_d;
    end
  end
endmodule

// File: rtl/link_frame_packer.sv
module link_frame_packer
  import lfp_pkg::*;
#(
  parameter int FRAME_W = 84,
  parameter int HDR_W   = 24,
  parameter int DATA_W  = 48,
  parameter int SIZE_W  = 8,
  parameter int BX_W    = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_stb_i,
  input  logic                     sync_i,
  input  logic [BX_W-1:0]          bxid_i,
  input  logic [FRAME_W-HDR_W-1:0] align_pat_i,
  input  logic                     ev_empty_i,
  input  logic [HDR_W-1:0]         ev_hdr_i,
  input  logic [DATA_W-1:0]        ev_data_i,
  output logic                     ev_rd_o,
  output logic [FRAME_W+3:0]       frame_o,
  output logic                     frame_vld_o
);
  localparam int ITEM_W = HDR_W + DATA_W;
  localparam int LEN_W  = $clog2(ITEM_W + 1);
  localparam int ACC_W  = 2 * FRAME_W;
  localparam int FILL_W = $clog2(ACC_W + 1);

  logic [ITEM_W-1:0]  item;
  logic [LEN_W-1:0]   item_len;
  frame_kind_e        kind;
  logic [FRAME_W-1:0] bits;
  logic [FILL_W-1:0]  fill;

  lfp_item_fmt #(
    .HDR_W(HDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
    .ITEM_W(ITEM_W), .LEN_W(LEN_W)
  ) u_fmt (
    .hdr_i (ev_hdr_i),
    .data_i(ev_data_i),
    .item_o(item),
    .len_o (item_len)
  );

  lfp_accum #(
    .FRAME_W(FRAME_W), .ITEM_W(ITEM_W), .LEN_W(LEN_W),
    .ACC_W(ACC_W), .FILL_W(FILL_W)
  ) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_stb_i(frame_stb_i),
    .sync_i     (sync_i),
    .ev_empty_i (ev_empty_i),
    .item_i     (item),
    .len_i      (item_len),
    .rd_o       (ev_rd_o),
    .kind_o     (kind),
    .bits_o     (bits),
    .fill_o     (fill)
  );

  lfp_frame_out #(
    .FRAME_W(FRAME_W), .HDR_W(HDR_W), .BX_W(BX_W)
  ) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_stb_i(frame_stb_i),
    .kind_i     (kind),
    .bits_i     (bits),
    .bxid_i     (bxid_i),
    .pat_i      (align_pat_i),
    .frame_o    (frame_o),
    .vld_o      (frame_vld_o)
  );
endmodule

// File: rtl/lfp_checker.sv
module lfp_checker #(
  parameter int FRAME_W = 84,
  parameter int BX_W    = 12,
  parameter int ACC_W   = 168,
  parameter int FILL_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_stb_i,
  input logic               sync_i,
  input logic [BX_W-1:0]    bxid_i,
  input logic               ev_empty_i,
  input logic               ev_rd_o,
  input logic [FRAME_W+3:0] frame_o,
  input logic               frame_vld_o,
  input logic [FILL_W-1:0]  fill_i
);
  logic [3:0] code;
  assign code = frame_o[FRAME_W+3:FRAME_W];

  // R2
  vld_after_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_i |=> frame_vld_o);
  // R2
  no_stray_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_stb_i |=> !frame_vld_o);
  // R1
  frame_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |-> (code == 4'h5 || code == 4'h6));
  // R7
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_o && code == 4'h6) |-> (frame_o[FRAME_W-1:0] == '0));
  // R8
  no_rd_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_empty_i |-> !ev_rd_o);
  // R8
  no_rd_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |-> !ev_rd_o);
  // R8
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= FILL_W'(ACC_W));
  // R9
  sync_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_stb_i && sync_i) |=> (code == 4'h5 && frame_o[BX_W-1:0] == $past(bxid_i)));
  // R10
  sync_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (fill_i == '0));
endmodule

bind link_frame_packer lfp_checker #(
  .FRAME_W(FRAME_W), .BX_W(BX_W), .ACC_W(ACC_W), .FILL_W(FILL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_stb_i(frame_stb_i),
  .sync_i     (sync_i),
  .bxid_i     (bxid_i),
  .ev_empty_i (ev_empty_i),
  .ev_rd_o    (ev_rd_o),
  .frame_o    (frame_o),
  .frame_vld_o(frame_vld_o),
  .fill_i     (fill)
);

// File: tb/link_frame_packer_test.sv
`timescale 1ns/1ps
module link_frame_packer_test;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        frame_stb_i = 0;
  logic        sync_i = 0;
  logic [11:0] bxid_i = 0;
  logic [59:0] align_pat_i = 0;
  logic        ev_empty_i = 1;
  logic [23:0] ev_hdr_i = 0;
  logic [47:0] ev_data_i = 0;
  logic        ev_rd_o;
  logic [87:0] frame_o;
  logic        frame_vld_o;

  always #4 clk_i = ~clk_i;

  link_frame_packer uut (.*);

  typedef struct { logic [23:0] h; logic [47:0] d; } ev_t;
  ev_t fifo[$];
  bit  bitq[$];
  int  checks = 0;
  int  failures = 0;
  bit  post_sync = 0;
  string data_tag = "R4";

  task automatic chk(bit ok, string req, logic [87:0] act, logic [87:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [83:0] head_bits();
    logic [83:0] r = '0;
    for (int i = 0; i < 84; i++) if (i < bitq.size()) r[i] = bitq[i];
    return r;
  endfunction

  function automatic int ev_len(ev_t e);
    return 24 + int'(e.h[23:16]);
  endfunction

  task automatic push_ev(int size, logic [11:0] bx);
    ev_t e;
    e.d = {$urandom, $urandom};
    e.h = {8'(size), 4'($urandom), bx};
    fifo.push_back(e);
  endtask

  task automatic step(bit stb, bit syn);
    logic [87:0] e = '0;
    string tag = "R7";
    bit rd;
    int after;
    frame_stb_i = stb;
    sync_i      = syn;
    bxid_i      = 12'($urandom);
    align_pat_i = 60'({$urandom, $urandom});
    ev_empty_i  = (fifo.size() == 0);
    if (fifo.size() != 0) begin
      ev_hdr_i  = fifo[0].h;
      ev_data_i = fifo[0].d;
    end else begin
      ev_hdr_i  = 24'($urandom);
      ev_data_i = {$urandom, $urandom};
    end
    #1;
    rd = ev_rd_o;
    after = bitq.size();
    if (syn) begin
      e = {4'h5, align_pat_i, 12'h000, bxid_i}; tag = "R9";
    end else if (bitq.size() >= 84) begin
      e = {4'h5, head_bits()}; tag = post_sync ? "R10" : data_tag;
      if (stb) after = bitq.size() - 84;
    end else if (bitq.size() > 0 && ev_empty_i) begin
      e = {4'h5, head_bits()}; tag = post_sync ? "R10" : "R6";
      if (stb) after = 0;
    end else begin
      e = {4'h6, 84'h0};
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk(frame_vld_o == stb, "R2", 88'(frame_vld_o), 88'(stb));
    if (stb) begin
      chk(frame_o[87:84] == e[87:84], "R1", frame_o, e);
      chk(frame_o == e, tag, frame_o, e);
      if (!syn && e[87:84] == 4'h5) post_sync = 0;
    end
    if (syn) begin
      bitq.delete();
      post_sync = 1;
    end else if (after < bitq.size()) begin
      repeat (bitq.size() - after) void'(bitq.pop_front());
    end
    if (rd) begin
      chk(!ev_empty_i && !syn && (after + ev_len(fifo[0]) <= 168), "R8",
          88'(after + ev_len(fifo[0])), 88'd168);
      if (fifo.size() != 0) begin
        for (int i = 0; i < 24; i++) bitq.push_back(fifo[0].h[i]);
        for (int i = 0; i < int'(fifo[0].h[23:16]); i++) bitq.push_back(fifo[0].d[i]);
        void'(fifo.pop_front());
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    // R11 during and after reset
    chk(frame_o == '0 && !frame_vld_o, "R11", frame_o, '0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(frame_o == '0 && !frame_vld_o, "R11", frame_o, '0);

    // R6: three header-only events flushed together
    for (int i = 0; i < 3; i++) push_ev(0, 12'(i + 1));
    repeat (5) step(0, 0);
    step(1, 0);
    step(1, 0); // R7 idle, nothing staged

    // R3 and R5: full-payload events with junk above size
    data_tag = "R3";
    push_ev(20, 12'h0a1); push_ev(48, 12'h0a2); push_ev(7, 12'h0a3);
    repeat (4) step(0, 0);
    for (int i = 0; i < 4; i++) step(1, 0);
    data_tag = "R4";

    // R7: partial staged while FIFO still holds data is idle
    push_ev(48, 12'h0b1);
    step(0, 0);
    push_ev(48, 12'h0b2);
    step(1, 0);
    repeat (6) step(i_dummy(), 0);

    // R9 then R10: staged bits discarded by synchronisation
    push_ev(30, 12'h0c1);
    step(0, 0);
    for (int i = 0; i < 3; i++) begin step(1, 1); step(0, 1); end
    push_ev(0, 12'h0c2);
    repeat (3) step(0, 0);
    step(1, 0);
    step(1, 0);

    // mixed random traffic
    begin
      int syn_left = 0;
      for (int c = 0; c < 6000; c++) begin
        if (fifo.size() < 8 && ($urandom % 3) == 0)
          push_ev(($urandom % 3 == 0) ? 0 : int'($urandom_range(1, 48)), 12'($urandom));
        if (syn_left == 0 && ($urandom % 300) == 0) syn_left = int'($urandom_range(1, 8));
        step((c % 3) == 0, syn_left != 0);
        if (syn_left != 0) syn_left--;
      end
    end
    while (fifo.size() != 0 || bitq.size() != 0) step(1, 0);
    step(1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic bit i_dummy();
    return 1'b1;
  endfunction
endmodule